// File: doc/BRIEF.md
# Receive Deframer with CRC Check

This block sits behind the symbol detector of a low-rate radio receiver and turns a stream of demodulated bytes into stored frames. While idle it looks for a run of zero preamble bytes closed by a fixed start-delimiter byte. The next byte gives the number of bytes that follow. Those bytes are the payload and the two check bytes. They are written in order into an on-chip buffer that the host reads through a simple address/data port. A CRC-16 is run over every stored byte, and the frame is marked good when the register ends at zero.

A link-quality figure is captured alongside each frame. It is the mean of the per-cycle energy samples over a fixed window that opens at the delimiter. The host picks how it is told about traffic. In packet reporting it gets one interrupt pulse per complete frame. In streaming reporting it gets one pulse per stored byte, with that byte shown on a word output. If the host fails to acknowledge a streamed byte before the next one lands, a sticky overrun flag is raised.

Top module: `rx_deframer`

## Requirements
- R1: While `rst` is high on a clock edge, and after that edge, `irq`, `frame_ok`, `overrun`, `frame_len`, `word_out` and `lqi` are all zero.
- R2: The delimiter byte 0xA7 is accepted only when at least four consecutive 0x00 bytes directly precede it. Any other byte clears the zero count. An 0xA7 seen after fewer zeros leaves the block searching.
- R3: The byte after the delimiter is the length L. A value from 2 to 127 is accepted and appears on `frame_len` one cycle later. Any other value drops the frame, with no buffer write, no interrupt, and no change to `frame_len`.
- R4: The L bytes after an accepted length are written to buffer addresses 0 to L-1 in arrival order. `rd_data` returns the byte at `rd_addr` one cycle after the address is presented.
- R5: A CRC-16 with reflected polynomial 0x8408 (x^16+x^12+x^5+1), initial value 0, and data bits taken LSB first is run over all L stored bytes. One cycle after the last byte, `frame_ok` becomes 1 if the result is zero and 0 otherwise. It holds until the end of the next frame.
- R6: With `stream_mode` low, exactly one single-cycle `irq` pulse is given per accepted frame, in the cycle after its last byte. No pulse is given for any other byte.
- R7: With `stream_mode` high, every stored byte produces an `irq` pulse in the next cycle, with that byte on `word_out`. `word_out` changes at no other time.
- R8: In streaming reporting, `overrun` is set when a byte is stored while the previous streamed byte has not been acknowledged by `host_ack`. An acknowledge in the same cycle counts as in time. The flag is cleared when the next delimiter is accepted.
- R9: `lqi` is updated to the floor of the mean of `energy` over the WIN (default 1024) cycles that follow the delimiter edge. It keeps its value otherwise. A new delimiter restarts the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 16 MHz in the target system |
| rst | input | 1 | Synchronous active-high reset |
| stream_mode | input | 1 | 1 = interrupt per byte, 0 = interrupt per frame |
| in_valid | input | 1 | A detected byte is present this cycle |
| in_byte | input | 8 | Detected byte |
| energy | input | 8 | Per-cycle energy sample |
| host_ack | input | 1 | Host has taken the current streamed byte |
| rd_addr | input | 7 | Buffer read address |
| rd_data | output | 8 | Buffer read data, one cycle latency |
| irq | output | 1 | Interrupt pulse |
| frame_ok | output | 1 | CRC result of the last completed frame |
| frame_len | output | 8 | Length byte of the last accepted frame |
| lqi | output | 8 | Link-quality average |
| word_out | output | 8 | Last streamed byte |
| overrun | output | 1 | Sticky streamed-byte overrun flag |

## Verification
A wrong hunt count or a wrong state shows up as a missing or extra change on `frame_len`, one cycle after the length byte, or as interrupts that should not occur. The reference model flags either on the clock where it happens. A fault in the CRC register or the byte counter first appears on `frame_ok` or as a misplaced `irq`, one cycle after the frame's last byte. A bad buffer address is seen as soon as the host reads back. Faults in the link-quality accumulator or window counter stay hidden until the window closes, up to WIN cycles after the delimiter.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    PS_HUNT = 2'd0,
    PS_LEN  = 2'd1,
    PS_BODY = 2'd2
  } pstate_t;

  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
endpackage

// File: rtl/rxd_parser.sv
module rxd_parser
  import rxd_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 7,
  parameter int MIN_LEN = 2,
  parameter int MAX_LEN = 127,
  parameter int PRE_MIN = 4,
  parameter logic [DW-1:0] SFD = 8'hA7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  output logic          start_o,
  output logic          hdr_ok_o,
  output logic          store_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] len_o
);
  localparam int ZW = $clog2(PRE_MIN + 1);
  localparam logic [ZW-1:0] ZSAT   = ZW'(PRE_MIN);
  localparam logic [DW-1:0] LEN_LO = DW'(MIN_LEN);
  localparam logic [DW-1:0] LEN_HI = DW'(MAX_LEN);

  pstate_t       st;
  logic [ZW-1:0] zcnt;
  logic [DW-1:0] rem;
  logic          len_ok;

  always_comb begin
    len_ok   = (in_byte >= LEN_LO) && (in_byte <= LEN_HI);
    start_o  = in_valid && (st == PS_HUNT) && (in_byte == SFD) && (zcnt == ZSAT);
    hdr_ok_o = in_valid && (st == PS_LEN) && len_ok;
    store_o  = in_valid && (st == PS_BODY);
    last_o   = store_o && (rem == DW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PS_HUNT;
      zcnt   <= '0;
      rem    <= '0;
      addr_o <= '0;
      len_o  <= '0;
    end else if (in_valid) begin
      case (st)
        PS_HUNT: begin
          if (start_o) begin
            st   <= PS_LEN;
            zcnt <= '0;
          end else if (in_byte == '0) begin
            zcnt <= (zcnt == ZSAT) ? zcnt : zcnt + ZW'(1);
          end else begin
            zcnt <= '0;
          end
        end
        PS_LEN: begin
          if (len_ok) begin
            st     <= PS_BODY;
            len_o  <= in_byte;
            rem    <= in_byte;
            addr_o <= '0;
          end else begin
            st <= PS_HUNT;
          end
        end
        PS_BODY: begin
          addr_o <= addr_o + AW'(1);
          rem    <= rem - DW'(1);
          if (rem == DW'(1)) st <= PS_HUNT;
        end
        default: st <= PS_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/rxd_crc16.sv
module rxd_crc16
  import rxd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  output logic [15:0]   next_o
);
  logic [15:0] crc_q;

  always_comb begin
    logic [15:0] r;
    r = crc_q;
    for (int i = 0; i < DW; i++) begin
      if (r[0] ^ data_i[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else                  r = r >> 1;
    end
    next_o = r;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) crc_q <= '0;
    else if (en_i)    crc_q <= next_o;
  end
endmodule

// File: rtl/rxd_lqi_avg.sv
module rxd_lqi_avg #(
  parameter int EW  = 8,
  parameter int WIN = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [EW-1:0] energy_i,
  output logic [EW-1:0] lqi_o
);
  localparam int CW = $clog2(WIN);
  localparam int SW = EW + CW;
  localparam logic [CW-1:0] CNT_LAST = CW'(WIN - 1);

  logic [SW-1:0] acc;
  logic [SW-1:0] sum;
  logic [CW-1:0] cnt;
  logic          active;

  assign sum = acc + SW'(energy_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      cnt    <= '0;
      active <= 1'b0;
      lqi_o  <= '0;
    end else if (start_i) begin
      acc    <= '0;
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      acc <= sum;
      cnt <= cnt + CW'(1);
      if (cnt == CNT_LAST) begin
        lqi_o  <= sum[SW-1:CW];
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxd_buffer.sv
module rxd_buffer #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  always_ff @(posedge clk) begin
    rd_o <= mem[ra_i];
  end
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer #(
  parameter int DW      = 8,
  parameter int AW      = 7,
  parameter int EW      = 8,
  parameter int MIN_LEN = 2,
  parameter int MAX_LEN = 127,
  parameter int PRE_MIN = 4,
  parameter int WIN     = 1024,
  parameter logic [DW-1:0] SFD = 8'hA7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stream_mode,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  input  logic [EW-1:0] energy,
  input  logic          host_ack,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          frame_ok,
  output logic [DW-1:0] frame_len,
  output logic [EW-1:0] lqi,
  output logic [DW-1:0] word_out,
  output logic          overrun
);
  logic          start;
  logic          hdr_ok;
  logic          store;
  logic          last;
  logic [AW-1:0] waddr;
  logic [15:0]   crc_next;
  logic          pend;

  rxd_parser #(
    .DW(DW), .AW(AW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
    .PRE_MIN(PRE_MIN), .SFD(SFD)
  ) u_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .start_o(start), .hdr_ok_o(hdr_ok), .store_o(store), .last_o(last),
    .addr_o(waddr), .len_o(frame_len)
  );

  rxd_crc16 #(.DW(DW)) u_crc (
    .clk(clk), .rst(rst), .clr_i(hdr_ok), .en_i(store),
    .data_i(in_byte), .next_o(crc_next)
  );

  rxd_buffer #(.DW(DW), .AW(AW)) u_buf (
    .clk(clk), .we_i(store), .wa_i(waddr), .wd_i(in_byte),
    .ra_i(rd_addr), .rd_o(rd_data)
  );

  rxd_lqi_avg #(.EW(EW), .WIN(WIN)) u_lqi (
    .clk(clk), .rst(rst), .start_i(start), .energy_i(energy), .lqi_o(lqi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      frame_ok <= 1'b0;
      word_out <= '0;
      overrun  <= 1'b0;
      pend     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (store && stream_mode) begin
        word_out <= in_byte;
        irq      <= 1'b1;
        pend     <= 1'b1;
        if (pend && !host_ack) overrun <= 1'b1;
      end else if (host_ack || start) begin
        pend <= 1'b0;
      end
      if (last) begin
        frame_ok <= (crc_next == 16'h0000);
        if (!stream_mode) irq <= 1'b1;
      end
      if (start) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_deframer_chk.sv
module rx_deframer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          irq,
  input logic          frame_ok,
  input logic [DW-1:0] frame_len,
  input logic [DW-1:0] word_out,
  input logic          overrun
);
  // R6
  irq_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(in_valid));

  // R7
  word_only_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !irq |-> $stable(word_out));

  // R8
  overrun_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> irq);

  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_len == '0) || ((frame_len >= DW'(2)) && (frame_len <= DW'(127))));

  // R5
  crc_flag_move_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_ok != $past(frame_ok)) |-> $past(in_valid));
endmodule

bind rx_deframer rx_deframer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .irq(irq),
  .frame_ok(frame_ok), .frame_len(frame_len), .word_out(word_out),
  .overrun(overrun)
);

// File: tb/rx_deframer_tb_top.sv
`timescale 1ns/1ps
module rx_deframer_tb_top;
  localparam int WIN = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stream_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [7:0] energy = 8'h00;
  logic       host_ack = 1'b0;
  logic [6:0] rd_addr = 7'd0;
  logic [7:0] rd_data;
  logic       irq;
  logic       frame_ok;
  logic [7:0] frame_len;
  logic [7:0] lqi;
  logic [7:0] word_out;
  logic       overrun;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  bit ack_auto = 1;
  bit e_ramp = 0;
  int e_const = 40;
  int ecyc = 0;
  int irq_cnt = 0;
  int last_pay[$];

  // model state
  bit m_armed = 0;
  int m_st, m_z, m_len, m_rem, m_addr, m_crc;
  int m_irq, m_ok, m_word, m_ovr, m_pend, m_lqi, m_lacc, m_lcnt, m_lact;
  int m_rd;
  bit m_rdk;
  int mram [128];
  bit mval [128];
  int mb;
  bit m_start, m_wordev;

  always #4 clk = ~clk;

  rx_deframer dut_i (
    .clk(clk), .rst(rst), .stream_mode(stream_mode), .in_valid(in_valid),
    .in_byte(in_byte), .energy(energy), .host_ack(host_ack), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .frame_ok(frame_ok), .frame_len(frame_len),
    .lqi(lqi), .word_out(word_out), .overrun(overrun)
  );

  function automatic int bcrc(input int c, input int d);
    int r = c;
    for (int k = 0; k < 8; k++) begin
      int fb = (r ^ (d >> k)) & 1;
      r = r >> 1;
      if (fb != 0) r = r ^ 'h8408;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, one step per clock
  always @(posedge clk) begin
    if (rst) begin
      m_armed = 1; m_st = 0; m_z = 0; m_len = 0; m_rem = 0; m_addr = 0; m_crc = 0;
      m_irq = 0; m_ok = 0; m_word = 0; m_ovr = 0; m_pend = 0;
      m_lqi = 0; m_lacc = 0; m_lcnt = 0; m_lact = 0; m_rdk = 0;
    end else begin
      mb = int'(in_byte);
      m_rd = mram[rd_addr];
      m_rdk = mval[rd_addr];
      m_irq = 0;
      m_wordev = 0;
      m_start = in_valid && m_st == 0 && mb == 'hA7 && m_z >= 4;
      if (m_start) begin
        m_lacc = 0; m_lcnt = 0; m_lact = 1;
      end else if (m_lact) begin
        m_lacc += int'(energy);
        m_lcnt++;
        if (m_lcnt == WIN) begin
          m_lqi = m_lacc / WIN;
          m_lact = 0;
        end
      end
      if (in_valid) begin
        if (m_st == 0) begin
          if (m_start) begin m_st = 1; m_z = 0; m_ovr = 0; m_pend = 0; end
          else if (mb == 0) m_z++;
          else m_z = 0;
        end else if (m_st == 1) begin
          if (mb >= 2 && mb <= 127) begin
            m_len = mb; m_rem = mb; m_addr = 0; m_crc = 0; m_st = 2;
          end else begin
            m_st = 0; m_z = 0;
          end
        end else begin
          mram[m_addr] = mb;
          mval[m_addr] = 1;
          m_crc = bcrc(m_crc, mb);
          m_addr++;
          m_rem--;
          if (stream_mode) begin
            m_word = mb; m_irq = 1; m_wordev = 1;
            if (m_pend && !host_ack) m_ovr = 1;
            m_pend = 1;
          end
          if (m_rem == 0) begin
            m_ok = (m_crc == 0);
            if (!stream_mode) m_irq = 1;
            m_st = 0; m_z = 0;
          end
        end
      end
      if (!m_wordev && host_ack) m_pend = 0;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (m_armed && !done) begin
      chk(irq === 1'(m_irq), "R6/R7 irq", int'(irq), m_irq);
      chk(frame_ok === 1'(m_ok), "R5 frame_ok", int'(frame_ok), m_ok);
      chk(frame_len === 8'(m_len), "R3 frame_len", int'(frame_len), m_len);
      chk(word_out === 8'(m_word), "R7 word_out", int'(word_out), m_word);
      chk(overrun === 1'(m_ovr), "R8 overrun", int'(overrun), m_ovr);
      chk(lqi === 8'(m_lqi), "R9 lqi", int'(lqi), m_lqi);
      if (m_rdk) chk(rd_data === 8'(m_rd), "R4 rd_data", int'(rd_data), m_rd);
      if (irq === 1'b1) irq_cnt++;
    end
  end

  always @(negedge clk) begin
    #1;
    host_ack = ack_auto & irq;
    energy = e_ramp ? 8'(ecyc) : 8'(e_const);
    ecyc++;
  end

  task automatic drive(input int b);
    @(negedge clk); #1;
    in_valid = 1'b1;
    in_byte = 8'(b);
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1;
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input int b, input int gap);
    drive(b);
    if (gap > 0) idle(gap - 1);
  endtask

  task automatic send_frame(input int npre, input int plen, input bit good,
                            input int gap, input int seed);
    int c = 0;
    last_pay.delete();
    for (int i = 0; i < npre; i++) put(0, gap);
    put('hA7, gap);
    put(plen + 2, gap);
    for (int i = 0; i < plen; i++) begin
      int b = (seed + i * 13 + 1) & 255;
      put(b, gap);
      c = bcrc(c, b);
      last_pay.push_back(b);
    end
    last_pay.push_back(good ? (c & 255) : ((c & 255) ^ 'h5A));
    last_pay.push_back((c >> 8) & 255);
    put(last_pay[plen], gap);
    put(last_pay[plen + 1], gap);
    idle(3);
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk); #1;
    rd_addr = 7'(a);
    @(negedge clk);
    chk(rd_data === 8'(exp), tag, int'(rd_data), exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(irq === 1'b0 && frame_ok === 1'b0 && overrun === 1'b0, "R1 flags", int'(irq), 0);
    chk(frame_len === 8'd0 && word_out === 8'd0 && lqi === 8'd0, "R1 values", int'(frame_len), 0);

    // packet mode good frame, constant energy 40
    irq_cnt = 0;
    send_frame(4, 10, 1'b1, 1, 3);
    chk(frame_ok === 1'b1, "R5 good frame", int'(frame_ok), 1);
    chk(frame_len === 8'd12, "R3 length", int'(frame_len), 12);
    chk(irq_cnt == 1, "R6 one irq", irq_cnt, 1);
    for (int i = 0; i < 12; i++) rd_chk(i, last_pay[i], "R4 readback");
    repeat (1100) @(negedge clk);
    chk(lqi === 8'd40, "R9 constant energy", int'(lqi), 40);

    // bad CRC
    send_frame(5, 7, 1'b0, 2, 50);
    chk(frame_ok === 1'b0, "R5 bad frame", int'(frame_ok), 0);

    // too-short preamble
    irq_cnt = 0;
    put(0, 1); put(0, 1); put(0, 1); put('hA7, 1); put(5, 1);
    for (int i = 0; i < 4; i++) put('h11, 1);
    idle(3);
    chk(frame_len === 8'd9, "R2 short preamble", int'(frame_len), 9);
    chk(irq_cnt == 0, "R2 no irq", irq_cnt, 0);

    // preamble broken by a non-zero byte
    put(0, 1); put(0, 1); put(1, 1); put(0, 1); put(0, 1); put(0, 1);
    put('hA7, 1); put(9, 1); put('h22, 1); put('h22, 1); idle(3);
    chk(frame_len === 8'd9, "R2 broken preamble", int'(frame_len), 9);
    send_frame(6, 4, 1'b1, 1, 77);
    chk(frame_len === 8'd6, "R2 long preamble accepted", int'(frame_len), 6);
    chk(frame_ok === 1'b1, "R5 after long preamble", int'(frame_ok), 1);

    // length out of range
    irq_cnt = 0;
    for (int i = 0; i < 4; i++) put(0, 1);
    put('hA7, 1); put(1, 1); put('h33, 1); put('h33, 1);
    for (int i = 0; i < 4; i++) put(0, 1);
    put('hA7, 1); put(128, 1); put('h33, 1); idle(3);
    chk(frame_len === 8'd6, "R3 reject length", int'(frame_len), 6);
    chk(irq_cnt == 0, "R3 no irq", irq_cnt, 0);
    rd_chk(0, last_pay[0], "R3 buffer untouched");

    // maximum length, back to back
    irq_cnt = 0;
    send_frame(4, 125, 1'b1, 0, 9);
    chk(frame_len === 8'd127, "R3 max length", int'(frame_len), 127);
    chk(frame_ok === 1'b1, "R5 max frame", int'(frame_ok), 1);
    chk(irq_cnt == 1, "R6 single irq", irq_cnt, 1);
    rd_chk(126, last_pay[126], "R4 last address");

    // streaming with prompt acknowledge
    stream_mode = 1'b1;
    ack_auto = 1;
    irq_cnt = 0;
    send_frame(4, 6, 1'b1, 0, 100);
    chk(irq_cnt == 8, "R7 irq per byte", irq_cnt, 8);
    chk(word_out === 8'(last_pay[7]), "R7 last word", int'(word_out), last_pay[7]);
    chk(overrun === 1'b0, "R8 no overrun", int'(overrun), 0);

    // streaming without acknowledge
    ack_auto = 0;
    send_frame(4, 3, 1'b1, 2, 7);
    chk(overrun === 1'b1, "R8 overrun set", int'(overrun), 1);
    ack_auto = 1;
    send_frame(4, 3, 1'b1, 2, 8);
    chk(overrun === 1'b0, "R8 cleared at delimiter", int'(overrun), 0);

    // window restart
    stream_mode = 1'b0;
    e_const = 200;
    send_frame(4, 2, 1'b1, 1, 1);
    repeat (300) @(negedge clk);
    e_const = 10;
    send_frame(4, 2, 1'b1, 1, 2);
    repeat (1100) @(negedge clk);
    chk(lqi === 8'd10, "R9 window restart", int'(lqi), 10);

    // ramp energy
    e_ramp = 1;
    send_frame(4, 5, 1'b1, 1, 4);
    repeat (1100) @(negedge clk);
    chk(lqi === 8'(m_lqi), "R9 ramp average", int'(lqi), m_lqi);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule